// File: doc/BRIEF.md
# Bit-Clear Flash Program and Sector Erase Controller

This block fronts a small byte array and makes it behave like NOR flash. A program request can only move bits from 1 to 0. The controller checks this rule in hardware before it writes. A request that would need any bit to go from 0 back to 1 is refused, and the stored byte is left as it was. The only way to return bits to 1 is a sector erase. An erase walks through the chosen sector one byte per cycle and writes 0xFF to each byte. Sectors grow in size towards the top of the address space, and a combinational lookup reports which sector an address falls in, together with that sector's first and last address.

Every operation is guarded by a lock. Two key bytes must be written, in the right order, before one program or erase is accepted. Accepting a request locks the controller again at once. A wrong key jams the lock until reset. If an erase and a program arrive in the same cycle, the erase runs first. The program then runs against the freshly erased contents, and the pair completes with a single done pulse.

Top module: `nor_pe_ctrl`

## Requirements
- R1: After reset every byte reads 0xFF, busy, done and error are 0, and unlocked is 0.
- R2: An accepted program whose data b satisfies (~a & b) == 0 against the stored byte a stores b. It raises busy for one cycle, and done pulses for one cycle with error at 0.
- R3: An accepted program with (~a & b) != 0 pulses done with error at 1 and leaves the stored byte unchanged.
- R4: An accepted erase of sector s writes 0xFF to every byte of s and to no other byte. Busy stays high for exactly as many cycles as s has bytes, and then done pulses with error at 0.
- R5: When erase_req and prog_req are both high in the accepting cycle, the erase runs first. The program then runs on the erased contents, busy lasts the sector size plus one cycle, and exactly one done pulse follows.
- R6: A request made while the lock is closed pulses done with error at 1 in the next cycle, and it changes no byte.
- R7: The lock opens only after key write KEY_A (default 0xA5) followed by KEY_B (default 0x5A). Accepting or rejecting any request closes it again, so a second request needs a new unlock.
- R8: A key write while the lock is closed or half open, whose value is not the expected key, jams the lock. A jammed lock ignores all later keys and rejects every request until reset.
- R9: With BASE bytes (default 8) and NUM_SECT sectors (default 4), sector 0 holds BASE bytes and sector i>0 holds BASE<<(i-1) bytes. The sectors are packed upward from address 0. For any addr, the outputs addr_sect, addr_lo and addr_hi give its sector and that sector's bounds.
- R10: Requests made while busy is high are ignored. They start nothing, change no byte and produce no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_we | input | 1 | Key write strobe |
| key_val | input | 8 | Key byte |
| prog_req | input | 1 | Program request |
| erase_req | input | 1 | Sector erase request |
| addr | input | ADDR_W | Program address, also drives the sector lookup |
| wdata | input | 8 | Program data |
| sect_id | input | SECT_W | Sector to erase |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Byte at rd_addr |
| addr_sect | output | SECT_W | Sector holding addr |
| addr_lo | output | ADDR_W | First address of that sector |
| addr_hi | output | ADDR_W | Last address of that sector |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Qualifies done: request refused or failed |
| unlocked | output | 1 | Lock currently open |

## Verification
The bench targets the bit rule at its edge. A program that only clears more bits must pass, and one that sets even a single bit must fail with the byte intact. A design that wrote the data anyway, or ANDed it in silently, would show a changed byte or a missing error. It then erases sectors of different sizes and counts busy cycles, while also checking a byte in the neighbouring sector. An off-by-one in the walk or the lookup would show up as a wrong cycle count or a corrupted neighbour. The test that raises both requests together, on a byte that had been programmed to zero, catches a design that drops the program or runs it before the erase, because the final value would then be wrong. Relock after use, a jammed lock after a wrong key, and a request arriving while an erase is running round out the set.

// File: rtl/nor_pe_pkg.sv
// Package: shared types and sector geometry for the flash controller.
// Assumes sector 0 holds BASE bytes and sector i>0 holds BASE<<(i-1) bytes.
package nor_pe_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_PROG, ST_ERASE} nor_state_e;

    typedef enum logic [1:0] {LK_SHUT, LK_HALF, LK_OPEN, LK_JAM} nor_lock_e;

    // First address of sector idx
    function automatic int unsigned sect_first(int unsigned base, int unsigned idx);
        return (idx == 0) ? 0 : (base << (idx - 1));
    endfunction

    // Last address of sector idx
    function automatic int unsigned sect_last(int unsigned base, int unsigned idx);
        return (base << idx) - 1;
    endfunction

endpackage

// File: rtl/nor_sector_map.sv
// Sector lookup: maps an address to its sector id and bounds.
// Assumes the geometry of nor_pe_pkg; purely combinational.
module nor_sector_map
    import nor_pe_pkg::*;
#(
    parameter int BASE     = 8,
    parameter int NUM_SECT = 4,
    parameter int ADDR_W   = 6,
    parameter int SECT_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SECT_W-1:0] sect,
    output logic [ADDR_W-1:0] lo,
    output logic [ADDR_W-1:0] hi
);

    logic [NUM_SECT-1:0] above;

    // One comparator per sector: is addr past this sector's last byte
    for (genvar i = 0; i < NUM_SECT; i++) begin : g_cmp
        assign above[i] = (32'(addr) > sect_last(BASE, i));
    end

    // Sector id is the number of sectors lying wholly below addr
    always_comb begin
        sect = SECT_W'($countones(above));
        lo   = ADDR_W'(sect_first(BASE, 32'(sect)));
        hi   = ADDR_W'(sect_last(BASE, 32'(sect)));
    end

endmodule

// File: rtl/nor_key_lock.sv
// Two-key lock guarding program and erase.
// Assumes consume pulses for one cycle per started request; consume beats key_we.
module nor_key_lock
    import nor_pe_pkg::*;
#(
    parameter logic [7:0] KEY_A = 8'hA5,
    parameter logic [7:0] KEY_B = 8'h5A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_we,
    input  logic [7:0] key_val,
    input  logic       consume,
    output logic       open
);

    nor_lock_e st;

    // Lock state walk: shut -> half -> open, any wrong key -> jam
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= LK_SHUT;
        end else if (consume) begin
            st <= (st == LK_JAM) ? LK_JAM : LK_SHUT;
        end else if (key_we) begin
            case (st)
                LK_SHUT: st <= (key_val == KEY_A) ? LK_HALF : LK_JAM;
                LK_HALF: st <= (key_val == KEY_B) ? LK_OPEN : LK_JAM;
                default: st <= st;
            endcase
        end
    end

    assign open = (st == LK_OPEN);

    AST_JAM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LK_JAM) |=> (st == LK_JAM));                                  // R8
    AST_OPEN_VIA_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open) |-> ($past(st) == LK_HALF));                             // R7

endmodule

// File: rtl/nor_cell_array.sv
// Byte storage: one write port, two asynchronous read ports.
// Assumes reset fills the array with the erased value 0xFF.
module nor_cell_array #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdat,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [7:0]        rdat_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [7:0]        rdat_b
);

    logic [7:0] mem [DEPTH];

    // Storage update: erased on reset, single write otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[waddr] <= wdat;
        end
    end

    assign rdat_a = mem[raddr_a];
    assign rdat_b = mem[raddr_b];

endmodule

// File: rtl/nor_pe_ctrl.sv
// Top: NOR-style program/erase sequencer with bit-clear check and key lock.
// Assumes requests are single-cycle pulses; requests during busy are dropped.
module nor_pe_ctrl
    import nor_pe_pkg::*;
#(
    parameter int         BASE     = 8,
    parameter int         NUM_SECT = 4,
    parameter logic [7:0] KEY_A    = 8'hA5,
    parameter logic [7:0] KEY_B    = 8'h5A,
    localparam int        DEPTH    = BASE << (NUM_SECT - 1),
    localparam int        ADDR_W   = $clog2(DEPTH),
    localparam int        SECT_W   = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_we,
    input  logic [7:0]        key_val,
    input  logic              prog_req,
    input  logic              erase_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [SECT_W-1:0] sect_id,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [SECT_W-1:0] addr_sect,
    output logic [ADDR_W-1:0] addr_lo,
    output logic [ADDR_W-1:0] addr_hi,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              unlocked
);

    nor_state_e        state;
    logic [ADDR_W-1:0] ptr, er_lo_q, er_hi_q, pa_q;
    logic [7:0]        pd_q, cur, mem_wd;
    logic              pend_q, done_q, err_q;
    logic              start, accept, sect_ok, fail, mem_we;
    logic [ADDR_W-1:0] mem_wa, tgt_lo, tgt_hi;

    nor_sector_map #(.BASE(BASE), .NUM_SECT(NUM_SECT), .ADDR_W(ADDR_W), .SECT_W(SECT_W))
        i_map (.addr(addr), .sect(addr_sect), .lo(addr_lo), .hi(addr_hi));

    nor_key_lock #(.KEY_A(KEY_A), .KEY_B(KEY_B))
        i_lock (.clk(clk), .rst_n(rst_n), .key_we(key_we), .key_val(key_val),
                .consume(start), .open(unlocked));

    nor_cell_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W))
        i_cells (.clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_wa), .wdat(mem_wd),
                 .raddr_a(pa_q), .rdat_a(cur), .raddr_b(rd_addr), .rdat_b(rd_data));

    // Request qualification and erase target bounds
    always_comb begin
        busy    = (state != ST_IDLE);
        start   = !busy && (prog_req || erase_req);
        sect_ok = (32'(sect_id) < NUM_SECT);
        accept  = start && unlocked && (!erase_req || sect_ok);
        tgt_lo  = ADDR_W'(sect_first(BASE, 32'(sect_id)));
        tgt_hi  = ADDR_W'(sect_last(BASE, 32'(sect_id)));
    end

    // Array write port: erase fill or bit-clear-checked program
    always_comb begin
        fail   = |(~cur & pd_q);
        mem_we = (state == ST_ERASE) || ((state == ST_PROG) && !fail);
        mem_wa = (state == ST_ERASE) ? ptr : pa_q;
        mem_wd = (state == ST_ERASE) ? 8'hFF : (cur & pd_q);
    end

    // Sequencer: idle -> erase walk (-> program) or program -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ptr     <= '0;
            er_lo_q <= '0;
            er_hi_q <= '0;
            pa_q    <= '0;
            pd_q    <= '0;
            pend_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        pa_q <= addr;
                        pd_q <= wdata;
                        if (erase_req) begin
                            state   <= ST_ERASE;
                            ptr     <= tgt_lo;
                            er_lo_q <= tgt_lo;
                            er_hi_q <= tgt_hi;
                            pend_q  <= prog_req;
                        end else begin
                            state <= ST_PROG;
                        end
                    end else if (start) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end
                end
                ST_ERASE: begin
                    ptr <= ptr + 1'b1;
                    if (ptr == er_hi_q) begin
                        pend_q <= 1'b0;
                        if (pend_q) begin
                            state <= ST_PROG;
                        end else begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_PROG: begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                    err_q  <= fail;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done  = done_q;
    assign error = err_q;

    AST_RELOCK_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !unlocked);                                                // R7
    AST_ERASE_IN_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE) |-> (ptr >= er_lo_q && ptr <= er_hi_q));         // R4
    AST_PROG_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |=> ((cur & ~$past(cur)) == 8'h00));              // R3
    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                     // R10
    AST_LOOKUP_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= addr_lo) && (addr <= addr_hi));                             // R9

endmodule

// File: tb/test_nor_pe_ctrl.sv
// Directed bench for nor_pe_ctrl: one task per scenario, each self-checking.
module test_nor_pe_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          key_we = 1'b0;
    logic [7:0]    key_val = '0;
    logic          prog_req = 1'b0;
    logic          erase_req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [SW-1:0] sect_id = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic [SW-1:0] addr_sect;
    logic [AW-1:0] addr_lo, addr_hi;
    logic          busy, done, error, unlocked;

    int checks = 0;
    int errors = 0;
    int last_busy;
    logic last_err;

    nor_pe_ctrl i_nor_pe_ctrl (
        .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_val(key_val),
        .prog_req(prog_req), .erase_req(erase_req), .addr(addr), .wdata(wdata),
        .sect_id(sect_id), .rd_addr(rd_addr), .rd_data(rd_data),
        .addr_sect(addr_sect), .addr_lo(addr_lo), .addr_hi(addr_hi),
        .busy(busy), .done(done), .error(error), .unlocked(unlocked));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put_key(input logic [7:0] k);
        key_we = 1'b1; key_val = k;
        @(negedge clk);
        key_we = 1'b0;
    endtask

    task automatic read_byte(input int a, output int v);
        rd_addr = AW'(a);
        #1 v = int'(rd_data);
    endtask

    // Pulse a request, then count busy cycles until done is seen
    task automatic issue(input logic p, input logic e, input int a, input int d, input int s);
        prog_req = p; erase_req = e; addr = AW'(a); wdata = 8'(d); sect_id = SW'(s);
        @(negedge clk);
        prog_req = 1'b0; erase_req = 1'b0;
        last_busy = 0;
        for (int n = 0; n < 200; n++) begin
            if (done) break;
            if (busy) last_busy++;
            @(negedge clk);
        end
        last_err = error;
        check("done seen", int'(done), 1);
        @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 error", int'(error), 0);
        check("R1 unlocked", int'(unlocked), 0);
        read_byte(0, v);  check("R1 byte0", v, 8'hFF);
        read_byte(63, v); check("R1 byte63", v, 8'hFF);
    endtask

    task automatic t_lookup();
        addr = 6'd0;  #1;
        check("R9 sect a0", int'(addr_sect), 0); check("R9 hi a0", int'(addr_hi), 7);
        addr = 6'd15; #1;
        check("R9 sect a15", int'(addr_sect), 1); check("R9 lo a15", int'(addr_lo), 8);
        check("R9 hi a15", int'(addr_hi), 15);
        addr = 6'd16; #1;
        check("R9 sect a16", int'(addr_sect), 2); check("R9 hi a16", int'(addr_hi), 31);
        addr = 6'd40; #1;
        check("R9 sect a40", int'(addr_sect), 3); check("R9 lo a40", int'(addr_lo), 32);
        check("R9 hi a40", int'(addr_hi), 63);
        @(negedge clk);
    endtask

    task automatic t_locked();
        int v;
        issue(1'b1, 1'b0, 3, 8'h00, 0);
        check("R6 locked program error", int'(last_err), 1);
        read_byte(3, v); check("R6 byte untouched", v, 8'hFF);
        issue(1'b0, 1'b1, 0, 0, 1);
        check("R6 locked erase error", int'(last_err), 1);
    endtask

    task automatic t_program();
        int v;
        put_key(8'hA5); put_key(8'h5A);
        check("R7 opened", int'(unlocked), 1);
        issue(1'b1, 1'b0, 3, 8'hF0, 0);
        check("R2 error", int'(last_err), 0);
        check("R2 busy cycles", last_busy, 1);
        read_byte(3, v); check("R2 stored F0", v, 8'hF0);
        check("R7 relocked", int'(unlocked), 0);
        issue(1'b1, 1'b0, 3, 8'h00, 0);
        check("R7 second request rejected", int'(last_err), 1);
        put_key(8'hA5); put_key(8'h5A);
        issue(1'b1, 1'b0, 3, 8'h30, 0);
        check("R2 further clear ok", int'(last_err), 0);
        read_byte(3, v); check("R2 stored 30", v, 8'h30);
        put_key(8'hA5); put_key(8'h5A);
        issue(1'b1, 1'b0, 3, 8'h31, 0);
        check("R3 set bit refused", int'(last_err), 1);
        read_byte(3, v); check("R3 byte kept", v, 8'h30);
    endtask

    task automatic t_erase();
        int v;
        put_key(8'hA5); put_key(8'h5A);
        issue(1'b1, 1'b0, 9, 8'h11, 0);
        put_key(8'hA5); put_key(8'h5A);
        issue(1'b0, 1'b1, 0, 0, 0);
        check("R4 erase error", int'(last_err), 0);
        check("R4 sector0 busy", last_busy, 8);
        read_byte(3, v); check("R4 byte3 erased", v, 8'hFF);
        read_byte(9, v); check("R4 neighbour kept", v, 8'h11);
        put_key(8'hA5); put_key(8'h5A);
        issue(1'b0, 1'b1, 0, 0, 3);
        check("R4 sector3 busy", last_busy, 32);
    endtask

    task automatic t_combined();
        int v;
        put_key(8'hA5); put_key(8'h5A);
        issue(1'b1, 1'b0, 20, 8'h00, 0);
        read_byte(20, v); check("R5 pre zero", v, 8'h00);
        put_key(8'hA5); put_key(8'h5A);
        issue(1'b1, 1'b1, 20, 8'h7E, 2);
        check("R5 error", int'(last_err), 0);
        check("R5 busy cycles", last_busy, 17);
        read_byte(20, v); check("R5 program after erase", v, 8'h7E);
        read_byte(16, v); check("R5 rest erased", v, 8'hFF);
        check("R5 single done", int'(done), 0);
    endtask

    task automatic t_busy_ignore();
        int v;
        int extra;
        put_key(8'hA5); put_key(8'h5A);
        erase_req = 1'b1; sect_id = 2'd1;
        @(negedge clk);
        erase_req = 1'b0;
        repeat (3) @(negedge clk);
        prog_req = 1'b1; addr = 6'd5; wdata = 8'h00;
        @(negedge clk);
        prog_req = 1'b0;
        for (int n = 0; n < 50; n++) begin
            if (done) break;
            @(negedge clk);
        end
        check("R10 erase done", int'(done), 1);
        extra = 0;
        for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R10 no extra done", extra, 0);
        read_byte(5, v); check("R10 byte5 untouched", v, 8'hFF);
    endtask

    task automatic t_jam();
        int v;
        put_key(8'h33);
        put_key(8'hA5); put_key(8'h5A);
        check("R8 jammed stays shut", int'(unlocked), 0);
        issue(1'b1, 1'b0, 4, 8'h00, 0);
        check("R8 request rejected", int'(last_err), 1);
        read_byte(4, v); check("R8 byte untouched", v, 8'hFF);
        put_key(8'hA5); put_key(8'h33);
        do_reset();
        put_key(8'h5A);
        check("R8 wrong order jams", int'(unlocked), 0);
        do_reset();
        put_key(8'hA5); put_key(8'h5A);
        check("R8 reset clears jam", int'(unlocked), 1);
        issue(1'b1, 1'b0, 4, 8'h0F, 0);
        check("R8 program after reset", int'(last_err), 0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_lookup();
        t_locked();
        t_program();
        t_erase();
        t_combined();
        t_busy_ignore();
        t_jam();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule